// File: doc/BRIEF.md
# Pulse Length Watchdog

This block watches a vector of event lines and measures, for each line, how many consecutive clock cycles it has been high. Each line has its own programmable weight. The weights, like the event lines, also feed a contention unit elsewhere on the chip. When a pulse grows long enough to reach its weight, the lane's interrupt bit is set. The bit stays set until software clears it.

The block also records the longest pulse seen on each lane, so software can size weights from real traffic. An enable input freezes all state. A clear input wipes the interrupt vector and the recorded peaks.

The run counters saturate instead of wrapping. This fixes what happens at the top of the count range: a weight at the all-ones value is defined as "never interrupt". Bus access and weight storage live outside this block.

Top module: `pulse_len_monitor`

## Requirements
- R1: While `en_i` is high, the length of a pulse on lane i is 1 in its first high cycle. It grows by one in each further consecutive high cycle.
- R2: A run length saturates at 2^CNT_W-1 and stays there for as long as the event stays high.
- R3: One enabled cycle with the event low returns that lane's run length to zero. The next pulse then starts again from 1.
- R4: Lane i's bit of `irq_o` is set at the clock edge that ends an enabled high cycle whose run length is greater than or equal to that lane's weight. The weight of lane i is `weight_i[i*CNT_W +: CNT_W]`, and a weight of 0 fires on any enabled high cycle.
- R5: A lane whose weight equals 2^CNT_W-1 never sets its interrupt bit, however long the pulse lasts.
- R6: Interrupt bits are sticky. They drop only when reset is applied or when `clr_i` is sampled high. `clr_i` wins over a simultaneous new interrupt.
- R7: `max_len_o[i*CNT_W +: CNT_W]` holds the largest run length seen on lane i since reset or the last `clr_i`. During a new record pulse it follows the running length.
- R8: While `en_i` is low, the event inputs have no effect. Run lengths, interrupt bits and peaks all hold their values.
- R9: Lanes are independent. Activity on one lane never changes another lane's interrupt bit or peak.
- R10: An active-low asynchronous `rst_n` clears run lengths, interrupt bits and peaks to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Monitoring enable; low freezes all state |
| clr_i | input | 1 | Clears the interrupt bits and the recorded peaks |
| evt_i | input | N_EVENTS | Event lines, one per lane |
| weight_i | input | N_EVENTS*CNT_W | Per-lane threshold, lane i in bits [i*CNT_W +: CNT_W] |
| irq_o | output | N_EVENTS | Sticky per-lane interrupt vector |
| max_len_o | output | N_EVENTS*CNT_W | Per-lane longest pulse, lane i in bits [i*CNT_W +: CNT_W] |

## Verification
The bench builds the block with two lanes and a 3-bit count (N_EVENTS=2, CNT_W=3). With those values the saturation point of 7 is reached within a handful of cycles. That puts saturation, the all-ones "never fire" weight and a weight of zero all inside short directed runs. Two lanes are enough to show that one lane's pulses and thresholds leave the other lane untouched. They also let the bench line up a clear with a threshold crossing in the same cycle.

// File: rtl/plm_pkg.sv
package plm_pkg;

  // Next run length when the event is high: one more, held at the ceiling.
  function automatic int unsigned sat_next(input int unsigned cur, input int unsigned ceil_v);
    return (cur >= ceil_v) ? ceil_v : cur + 1;
  endfunction

  // Threshold test: a weight at the ceiling is reserved as "never".
  function automatic logic crosses(input int unsigned len, input int unsigned wt,
                                   input int unsigned ceil_v);
    return (wt != ceil_v) && (len >= wt);
  endfunction

endpackage

// File: rtl/plm_run_counter.sv
module plm_run_counter #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic             evt_i,
  output logic [CNT_W-1:0] len_o
);
  localparam int unsigned CEIL = (2 ** CNT_W) - 1;

  logic [CNT_W-1:0] run_q;

  // Length of the pulse including the current cycle (valid when evt_i is high).
  assign len_o = CNT_W'(plm_pkg::sat_next(32'(run_q), CEIL));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     run_q <= '0;
    else if (en_i)  run_q <= evt_i ? len_o : '0;
  end
endmodule

// File: rtl/plm_peak_hold.sv
module plm_peak_hold #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic             clr_i,
  input  logic             evt_i,
  input  logic [CNT_W-1:0] len_i,
  output logic [CNT_W-1:0] peak_o
);
  logic grow_w;
  assign grow_w = en_i && evt_i && (len_i > peak_o);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       peak_o <= '0;
    else if (clr_i)   peak_o <= '0;
    else if (grow_w)  peak_o <= len_i;
  end
endmodule

// File: rtl/plm_flag.sv
module plm_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic clr_i,
  input  logic hit_i,
  output logic flag_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              flag_o <= 1'b0;
    else if (clr_i)          flag_o <= 1'b0;
    else if (en_i && hit_i)  flag_o <= 1'b1;
  end
endmodule

// File: rtl/pulse_len_monitor.sv
module pulse_len_monitor #(
  parameter int unsigned N_EVENTS = 4,
  parameter int unsigned CNT_W    = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      en_i,
  input  logic                      clr_i,
  input  logic [N_EVENTS-1:0]       evt_i,
  input  logic [N_EVENTS*CNT_W-1:0] weight_i,
  output logic [N_EVENTS-1:0]       irq_o,
  output logic [N_EVENTS*CNT_W-1:0] max_len_o
);
  localparam int unsigned CEIL = (2 ** CNT_W) - 1;

  // Named internal events, visible to the bound checker.
  logic [CNT_W-1:0]    len_w [N_EVENTS];
  logic [N_EVENTS-1:0] hit_w;

  for (genvar g = 0; g < N_EVENTS; g++) begin : g_lane
    plm_run_counter #(.CNT_W(CNT_W)) run_i (
      .clk   (clk),
      .rst_n (rst_n),
      .en_i  (en_i),
      .evt_i (evt_i[g]),
      .len_o (len_w[g])
    );

    assign hit_w[g] = evt_i[g] &&
      plm_pkg::crosses(32'(len_w[g]), 32'(weight_i[g*CNT_W +: CNT_W]), CEIL);

    plm_flag flag_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .en_i   (en_i),
      .clr_i  (clr_i),
      .hit_i  (hit_w[g]),
      .flag_o (irq_o[g])
    );

    plm_peak_hold #(.CNT_W(CNT_W)) peak_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .en_i   (en_i),
      .clr_i  (clr_i),
      .evt_i  (evt_i[g]),
      .len_i  (len_w[g]),
      .peak_o (max_len_o[g*CNT_W +: CNT_W])
    );
  end
endmodule

// File: rtl/pulse_len_monitor_checker.sv
module pulse_len_monitor_checker #(
  parameter int unsigned N_EVENTS = 4,
  parameter int unsigned CNT_W    = 8
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      en_i,
  input logic                      clr_i,
  input logic [N_EVENTS-1:0]       evt_i,
  input logic [N_EVENTS*CNT_W-1:0] weight_i,
  input logic [N_EVENTS-1:0]       irq_o,
  input logic [N_EVENTS*CNT_W-1:0] max_len_o
);
  localparam logic [CNT_W-1:0] CEIL = '1;

  a_r8_frozen_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_i && !clr_i) |=> ($stable(irq_o) && $stable(max_len_o)));

  a_r6_clear_wipes: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (irq_o == '0 && max_len_o == '0));

  a_r6_sticky_bits: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_i |=> ((irq_o & $past(irq_o)) == $past(irq_o)));

  for (genvar g = 0; g < N_EVENTS; g++) begin : g_chk
    a_r5_ceiling_weight_silent: assert property (@(posedge clk) disable iff (!rst_n)
      (weight_i[g*CNT_W +: CNT_W] == CEIL && !irq_o[g]) |=> !irq_o[g]);

    a_r4_rise_needs_event: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_o[g]) |-> ($past(evt_i[g]) && $past(en_i)));

    a_r7_peak_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_i |=> (max_len_o[g*CNT_W +: CNT_W] >= $past(max_len_o[g*CNT_W +: CNT_W])));
  end
endmodule

bind pulse_len_monitor pulse_len_monitor_checker #(
  .N_EVENTS(N_EVENTS), .CNT_W(CNT_W)
) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .en_i      (en_i),
  .clr_i     (clr_i),
  .evt_i     (evt_i),
  .weight_i  (weight_i),
  .irq_o     (irq_o),
  .max_len_o (max_len_o)
);

// File: tb/pulse_len_monitor_tb_top.sv
`timescale 1ns/1ps
module pulse_len_monitor_tb_top;
  localparam int unsigned NE = 2;
  localparam int unsigned CW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          en_i = 1'b0;
  logic          clr_i = 1'b0;
  logic [NE-1:0] evt_i = '0;
  logic [NE*CW-1:0] weight_i = '0;
  logic [NE-1:0] irq_o;
  logic [NE*CW-1:0] max_len_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pulse_len_monitor #(.N_EVENTS(NE), .CNT_W(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .en_i(en_i), .clr_i(clr_i), .evt_i(evt_i),
    .weight_i(weight_i), .irq_o(irq_o), .max_len_o(max_len_o)
  );

  // Row: evt[11:10] en[9] clr[8] irq[7:6] max0[5:3] max1[2:0]
  // Lane 0 weight 3, lane 1 weight 7 (ceiling).
  localparam logic [11:0] TAB [15] = '{
    {2'b01, 1'b1, 1'b0, 2'b00, 3'd1, 3'd0},
    {2'b11, 1'b1, 1'b0, 2'b00, 3'd2, 3'd1},
    {2'b11, 1'b1, 1'b0, 2'b01, 3'd3, 3'd2},
    {2'b10, 1'b1, 1'b0, 2'b01, 3'd3, 3'd3},
    {2'b11, 1'b0, 1'b0, 2'b01, 3'd3, 3'd3},
    {2'b00, 1'b1, 1'b1, 2'b00, 3'd0, 3'd0},
    {2'b10, 1'b1, 1'b0, 2'b00, 3'd0, 3'd1},
    {2'b10, 1'b1, 1'b0, 2'b00, 3'd0, 3'd2},
    {2'b10, 1'b0, 1'b0, 2'b00, 3'd0, 3'd2},
    {2'b10, 1'b1, 1'b0, 2'b00, 3'd0, 3'd3},
    {2'b11, 1'b1, 1'b0, 2'b00, 3'd1, 3'd4},
    {2'b11, 1'b1, 1'b0, 2'b00, 3'd2, 3'd5},
    {2'b01, 1'b1, 1'b0, 2'b01, 3'd3, 3'd5},
    {2'b01, 1'b1, 1'b1, 2'b00, 3'd0, 3'd0},
    {2'b01, 1'b1, 1'b0, 2'b01, 3'd5, 3'd0}
  };

  task automatic check(input string tag, input logic [NE-1:0] e_irq,
                       input logic [CW-1:0] e_m0, input logic [CW-1:0] e_m1);
    checks++;
    if (irq_o !== e_irq || max_len_o[0 +: CW] !== e_m0 || max_len_o[CW +: CW] !== e_m1) begin
      errors++;
      $display("FAIL %s: irq=%b max0=%0d max1=%0d expected irq=%b max0=%0d max1=%0d",
               tag, irq_o, max_len_o[0 +: CW], max_len_o[CW +: CW], e_irq, e_m0, e_m1);
    end
  endtask

  // Drive at a falling edge, let one rising edge pass, return at the next falling edge.
  task automatic step(input logic [NE-1:0] e, input logic en, input logic clr);
    evt_i = e; en_i = en; clr_i = clr;
    @(negedge clk);
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    weight_i = {3'd7, 3'd3};
    repeat (3) @(negedge clk);
    check("R10 reset state", 2'b00, 3'd0, 3'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // Table: R1 lengths, R3 restart, R4 threshold, R5 ceiling weight,
    // R6 sticky/clear priority, R7 peaks, R8 enable hold, R9 independence.
    for (int r = 0; r < 15; r++) begin
      step(TAB[r][11:10], TAB[r][9], TAB[r][8]);
      check($sformatf("R1/R4/R6/R7/R8/R9 table row %0d", r), TAB[r][7:6], TAB[r][5:3], TAB[r][2:0]);
    end

    // R2 saturation and R5 ceiling weight on lane 1; lane 0 weight 6.
    weight_i = {3'd7, 3'd6};
    step(2'b00, 1'b1, 1'b1);
    for (int c = 1; c <= 10; c++) begin
      step(2'b11, 1'b1, 1'b0);
      if (c == 5)  check("R4 below weight", 2'b00, 3'd5, 3'd5);
      if (c == 6)  check("R4 reaches weight", 2'b01, 3'd6, 3'd6);
      if (c == 10) check("R2 R5 saturated run", 2'b01, 3'd7, 3'd7);
    end

    // R3: a low cycle restarts the count.
    step(2'b00, 1'b1, 1'b1);
    step(2'b01, 1'b1, 1'b0);
    step(2'b01, 1'b1, 1'b0);
    check("R3 restart after low", 2'b00, 3'd2, 3'd0);

    // R4: weight zero fires on one high cycle.
    weight_i = {3'd7, 3'd0};
    step(2'b00, 1'b1, 1'b1);
    step(2'b01, 1'b1, 1'b0);
    check("R4 zero weight", 2'b01, 3'd1, 3'd0);

    // R8: disabled long pulse on lane 1 changes nothing.
    weight_i = {3'd1, 3'd0};
    for (int c = 0; c < 4; c++) step(2'b10, 1'b0, 1'b0);
    check("R8 disabled ignores events", 2'b01, 3'd1, 3'd0);

    // R10: asynchronous reset mid-run.
    step(2'b11, 1'b1, 1'b0);
    #1 rst_n = 1'b0;
    #1 check("R10 async reset", 2'b00, 3'd0, 3'd0);
    @(negedge clk);
    rst_n = 1'b1;

    done = 1'b1;
    summary();
    $finish;
  end
endmodule